// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block lets a host send bytes to a slave device as the single master of a two-wire bus. The host selects master transmit mode, confirms that the bus is free, and then asks for a start condition. It then feeds bytes through a transmit buffer that has a one-byte holding register in front of the shift register. The first byte after the start carries the slave address and the direction bit. The host reads the captured acknowledge bit to decide whether to continue. It finishes the transfer by asking for a stop condition and waiting for the stop flag.

The bus pins are open-drain. Each line is modelled as a pull-low enable plus a sampled input. A line monitor watches both sampled lines, so the bus-busy bit follows start and stop conditions from any master. Each bit takes four quarter periods of `DIV` system clocks: two with SCL low and two with SCL high.

Top module: `i2c_master_tx`

## Requirements
- R1: After reset, both line enables are 0, `bus_busy`, `xfer_end`, `stop_flag`, `is_master` and `is_xmit` are 0, and `buf_empty` is 1.
- R2: A command write with `cmd_busy`=1 and `cmd_cond`=0 produces a falling SDA while SCL is high, provided that the block is idle, in master transmit mode (`is_master`=1, `is_xmit`=1) and `bus_busy`=0. `bus_busy` then reads 1.
- R3: A start request is ignored if `bus_busy` is 1 or if the block is not in master transmit mode. In that case neither line is pulled low.
- R4: Bytes go out most significant bit first. SDA changes only while SCL is low. One SCL period lasts 4*`DIV` clock cycles.
- R5: `buf_empty` goes to 1 when the holding register moves into the shift register. A data write is accepted only while `buf_empty`=1, and it clears `buf_empty`. A write while `buf_empty`=0 is dropped.
- R6: `xfer_end` goes to 1 at the end of the ninth bit if no byte is waiting. It stays set until `clr_end` is pulsed or a data write is accepted.
- R7: The SDA level sampled during the high phase of the ninth clock is stored in `ack_bit`. A value of 0 means the slave acknowledged.
- R8: A command write with `cmd_busy`=0 and `cmd_cond`=0 during a transfer produces a rising SDA while SCL is high, once the buffer is drained. The block then clears `bus_busy`, sets the sticky `stop_flag` (cleared by `clr_stop`), and returns to `is_master`=0 and `is_xmit`=0.
- R9: A start or stop seen on the sampled lines from another source sets or clears `bus_busy`. A stop seen this way also sets `stop_flag`.
- R10: A mode write that turns `is_xmit` from 0 to 1 sets `buf_empty`. `clr_empty` clears `buf_empty` only while `is_xmit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_busy | input | 1 | Busy bit of the command write |
| cmd_cond | input | 1 | Start/stop control bit of the command write |
| mode_we | input | 1 | Mode write strobe |
| mode_master | input | 1 | Master bit of the mode write |
| mode_xmit | input | 1 | Transmit bit of the mode write |
| data_we | input | 1 | Transmit data write strobe |
| data_in | input | 8 | Transmit data byte |
| clr_end | input | 1 | Clear transmit-end flag |
| clr_stop | input | 1 | Clear stop flag |
| clr_empty | input | 1 | Clear buffer-empty flag |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| bus_busy | output | 1 | Bus between start and stop |
| buf_empty | output | 1 | Holding register may be written |
| xfer_end | output | 1 | Byte done and nothing waiting |
| stop_flag | output | 1 | Stop seen on the bus |
| ack_bit | output | 1 | Captured acknowledge bit, 0 = acknowledged |
| is_master | output | 1 | Master mode |
| is_xmit | output | 1 | Transmit mode |

## Verification
The assertions check the following on every cycle:
- both lines are released whenever the block is idle;
- SDA holds still through every SCL high phase of a data bit;
- a write to a full buffer leaves the stored byte alone;
- the end and stop flags stay set until cleared;
- a detected start raises busy;
- no start leaves idle while the bus is busy.

Only the bench scenarios can show the rest. These are the bit order and SCL period on the wire, acknowledge and no-acknowledge capture, the double-buffered hand-off across several bytes, and the return to slave receive mode after a stop. They also cover busy tracking of a start and stop driven by another master.

// File: rtl/i2c_master_tx.sv
module i2c_master_tx #(
  parameter int DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       cmd_busy,
  input  logic       cmd_cond,
  input  logic       mode_we,
  input  logic       mode_master,
  input  logic       mode_xmit,
  input  logic       data_we,
  input  logic [7:0] data_in,
  input  logic       clr_end,
  input  logic       clr_stop,
  input  logic       clr_empty,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       bus_busy,
  output logic       buf_empty,
  output logic       xfer_end,
  output logic       stop_flag,
  output logic       ack_bit,
  output logic       is_master,
  output logic       is_xmit
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_HOLD, S_BIT, S_STOP} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic [7:0]    sh, hold_q;
  logic          stop_req;
  logic          s_scl, s_sda, p_scl, p_sda;

  wire tick      = cnt == CW'(DIV - 1);
  wire q_last    = tick && q == 2'd3;
  wire timed     = st == S_START || st == S_BIT || st == S_STOP;
  wire data_acc  = data_we && buf_empty;
  wire start_go  = cmd_we && cmd_busy && !cmd_cond && st == S_IDLE &&
                   is_master && is_xmit && !bus_busy;
  wire stop_wr   = cmd_we && !cmd_busy && !cmd_cond && st != S_IDLE;
  wire byte_done = st == S_BIT && q_last && bitn == 4'd8;
  wire load      = !buf_empty && ((st == S_HOLD) || byte_done ||
                                  (st == S_START && q_last));
  wire stop_go   = st == S_HOLD && buf_empty && stop_req;
  wire start_det = p_scl && s_scl && p_sda && !s_sda;
  wire stop_det  = p_scl && s_scl && !p_sda && s_sda;

  assign scl_oe = (st == S_HOLD) || (st == S_START && q == 2'd3) ||
                  ((st == S_BIT || st == S_STOP) && q < 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      q <= '0;
      bitn <= '0;
    end else begin
      cnt <= (timed && !tick) ? cnt + 1'b1 : '0;
      q   <= !timed ? 2'd0 : (tick ? q + 2'd1 : q);
      if (load) bitn <= '0;
      else if (st == S_BIT && q_last) bitn <= bitn + 4'd1;
      case (st)
        S_IDLE:  if (start_go) st <= S_START;
        S_START: if (q_last) st <= buf_empty ? S_HOLD : S_BIT;
        S_HOLD:  if (!buf_empty) st <= S_BIT;
                 else if (stop_req) st <= S_STOP;
        S_BIT:   if (byte_done && buf_empty) st <= S_HOLD;
        S_STOP:  if (q_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
      sda_oe <= 1'b0;
      ack_bit <= 1'b1;
    end else begin
      if (load) sh <= hold_q;
      else if (st == S_BIT && tick && q == 2'd0) sh <= sh << 1;
      if (st == S_IDLE) sda_oe <= 1'b0;
      else if (st == S_START && tick && q == 2'd1) sda_oe <= 1'b1;
      else if (st == S_BIT && tick && q == 2'd0) sda_oe <= (bitn < 4'd8) ? !sh[7] : 1'b0;
      else if (st == S_STOP && tick && q == 2'd0) sda_oe <= 1'b1;
      else if (st == S_STOP && tick && q == 2'd2) sda_oe <= 1'b0;
      if (st == S_BIT && bitn == 4'd8 && tick && q == 2'd2) ack_bit <= sda_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      buf_empty <= 1'b1;
      xfer_end <= 1'b0;
      stop_flag <= 1'b0;
      stop_req <= 1'b0;
      is_master <= 1'b0;
      is_xmit <= 1'b0;
    end else begin
      if (data_acc) hold_q <= data_in;
      if (load) buf_empty <= 1'b1;
      else if (data_acc) buf_empty <= 1'b0;
      else if (mode_we && mode_xmit && !is_xmit) buf_empty <= 1'b1;
      else if (clr_empty && !is_xmit) buf_empty <= 1'b0;
      if (clr_end || data_acc) xfer_end <= 1'b0;
      else if (byte_done && buf_empty) xfer_end <= 1'b1;
      if (stop_det) stop_flag <= 1'b1;
      else if (clr_stop) stop_flag <= 1'b0;
      if (stop_go) stop_req <= 1'b0;
      else if (stop_wr) stop_req <= 1'b1;
      if (mode_we) begin
        is_master <= mode_master;
        is_xmit <= mode_xmit;
      end else if (st == S_STOP && q_last) begin
        is_master <= 1'b0;
        is_xmit <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {s_scl, s_sda, p_scl, p_sda} <= 4'b1111;
      bus_busy <= 1'b0;
    end else begin
      {s_scl, s_sda} <= {scl_in, sda_in};
      {p_scl, p_sda} <= {s_scl, s_sda};
      if (start_det) bus_busy <= 1'b1;
      else if (stop_det) bus_busy <= 1'b0;
    end
  end

  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !scl_oe && !sda_oe);
  p_sda_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_BIT && q >= 2'd2 |-> $stable(sda_oe));
  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_we && !buf_empty |=> $stable(hold_q));
  p_end_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end && !clr_end && !data_we |=> xfer_end);
  p_stop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag && !clr_stop |=> stop_flag);
  p_busy_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy);
  p_no_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && bus_busy |=> st == S_IDLE);
endmodule

// File: tb/i2c_master_tx_bench.sv
module i2c_master_tx_bench;
  localparam int CLK_NS = 10;
  localparam int DIV = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_we = 0, cmd_busy = 0, cmd_cond = 0;
  logic mode_we = 0, mode_master = 0, mode_xmit = 0;
  logic data_we = 0;
  logic [7:0] data_in = 0;
  logic clr_end = 0, clr_stop = 0, clr_empty = 0;
  logic scl_oe, sda_oe, bus_busy, buf_empty, xfer_end, stop_flag, ack_bit, is_master, is_xmit;
  logic slv_sda = 0, ext_sda = 0, ack_en = 1;
  wire scl_in = !scl_oe;
  wire sda_in = !(sda_oe || slv_sda || ext_sda);

  int tests = 0, fails = 0, cyc = 0;
  int bitcnt = 0, rx_n = 0, t_prev = 0, t_last = 0;
  logic [7:0] rx_sh = 0;
  logic [7:0] rx [0:7];

  i2c_master_tx #(.DIV(DIV)) u_i2c_master_tx (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_busy(cmd_busy), .cmd_cond(cmd_cond),
    .mode_we(mode_we), .mode_master(mode_master), .mode_xmit(mode_xmit),
    .data_we(data_we), .data_in(data_in), .clr_end(clr_end), .clr_stop(clr_stop),
    .clr_empty(clr_empty), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .bus_busy(bus_busy), .buf_empty(buf_empty), .xfer_end(xfer_end),
    .stop_flag(stop_flag), .ack_bit(ack_bit), .is_master(is_master), .is_xmit(is_xmit));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge scl_in) begin
    t_prev = t_last;
    t_last = cyc;
    if (bitcnt < 8) begin
      rx_sh = {rx_sh[6:0], sda_in};
      bitcnt = bitcnt + 1;
    end else begin
      if (rx_n < 8) rx[rx_n] = rx_sh;
      rx_n = rx_n + 1;
      bitcnt = 0;
    end
  end
  always @(negedge scl_in) slv_sda = (bitcnt == 8) && ack_en;
  always @(sda_in) if (scl_in) bitcnt = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_cmd(input logic b, input logic c);
    @(negedge clk); cmd_we = 1; cmd_busy = b; cmd_cond = c;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic set_mode(input logic m, input logic x);
    @(negedge clk); mode_we = 1; mode_master = m; mode_xmit = x;
    @(negedge clk); mode_we = 0;
  endtask
  task automatic put(input logic [7:0] d);
    @(negedge clk); data_we = 1; data_in = d;
    @(negedge clk); data_we = 0;
  endtask
  task automatic clr_s;
    @(negedge clk); clr_stop = 1; @(negedge clk); clr_stop = 0;
  endtask
  task automatic wait_end;
    for (int i = 0; i < 4000 && !xfer_end; i++) @(negedge clk);
  endtask
  task automatic wait_empty;
    for (int i = 0; i < 4000 && !buf_empty; i++) @(negedge clk);
  endtask
  task automatic do_stop;
    clr_s();
    pulse_cmd(0, 0);
    for (int i = 0; i < 4000 && !stop_flag; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 busy", bus_busy, 0); chk("R1 empty", buf_empty, 1);
    chk("R1 end", xfer_end, 0); chk("R1 stop", stop_flag, 0);
    chk("R1 mode", {is_master, is_xmit}, 0);
  endtask

  task automatic t_single;
    ack_en = 1; rx_n = 0;
    set_mode(1, 1);
    chk("R2 busy before", bus_busy, 0);
    pulse_cmd(1, 0);
    for (int i = 0; i < 100 && !bus_busy; i++) @(negedge clk);
    chk("R2 busy after start", bus_busy, 1);
    put(8'hA6);
    wait_end();
    chk("R6 end set", xfer_end, 1);
    chk("R4 byte msb first", rx[0], 8'hA6);
    chk("R4 scl period", t_last - t_prev, 4 * DIV);
    chk("R7 ack captured", ack_bit, 0);
    chk("R5 empty after load", buf_empty, 1);
    @(negedge clk); clr_end = 1; @(negedge clk); clr_end = 0;
    chk("R6 cleared by clr_end", xfer_end, 0);
    do_stop();
    chk("R8 stop flag", stop_flag, 1);
    chk("R8 busy cleared", bus_busy, 0);
    chk("R8 back to slave rx", {is_master, is_xmit}, 0);
    chk("R8 lines released", {scl_oe, sda_oe}, 0);
    repeat (10) @(negedge clk);
    chk("R8 stop sticky", stop_flag, 1);
    clr_s();
    chk("R8 stop cleared", stop_flag, 0);
  endtask

  task automatic t_multi;
    ack_en = 1; rx_n = 0;
    set_mode(1, 1);
    pulse_cmd(1, 0);
    put(8'h3C);
    put(8'hFF);
    chk("R5 full write dropped, empty still 0", buf_empty, 0);
    wait_empty();
    put(8'h81);
    chk("R6 no end while byte waiting", xfer_end, 0);
    wait_end();
    chk("R5 rx count", rx_n, 2);
    chk("R5 first byte", rx[0], 8'h3C);
    chk("R5 second byte", rx[1], 8'h81);
    put(8'h5A);
    chk("R6 cleared by data write", xfer_end, 0);
    wait_end();
    chk("R4 third byte", rx[2], 8'h5A);
    do_stop();
    chk("R8 stop after multi", stop_flag, 1);
    clr_s();
  endtask

  task automatic t_nack;
    ack_en = 0; rx_n = 0;
    set_mode(1, 1);
    pulse_cmd(1, 0);
    put(8'h11);
    wait_end();
    chk("R7 nack captured", ack_bit, 1);
    do_stop();
    clr_s();
    ack_en = 1;
  endtask

  task automatic t_ignored;
    set_mode(0, 0);
    pulse_cmd(1, 0);
    repeat (40) @(negedge clk);
    chk("R3 no start outside master tx", bus_busy, 0);
    chk("R3 lines idle", {scl_oe, sda_oe}, 0);
    set_mode(1, 1);
    @(negedge clk); ext_sda = 1;
    repeat (5) @(negedge clk);
    chk("R9 external start sets busy", bus_busy, 1);
    pulse_cmd(1, 0);
    repeat (40) @(negedge clk);
    chk("R3 no start while busy", {scl_oe, sda_oe}, 0);
    ext_sda = 0;
    repeat (5) @(negedge clk);
    chk("R9 external stop clears busy", bus_busy, 0);
    chk("R9 external stop flag", stop_flag, 1);
    clr_s();
  endtask

  task automatic t_empty_ctl;
    set_mode(1, 1);
    @(negedge clk); clr_empty = 1; @(negedge clk); clr_empty = 0;
    chk("R10 clr ignored in tx mode", buf_empty, 1);
    set_mode(0, 0);
    @(negedge clk); clr_empty = 1; @(negedge clk); clr_empty = 0;
    chk("R10 clr in slave mode", buf_empty, 0);
    set_mode(1, 1);
    chk("R10 tx entry sets empty", buf_empty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_nack();
    t_ignored();
    t_empty_ctl();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule